// File: doc/BRIEF.md
# Burst-Capable Bus Cycle Controller

This block is the master-side sequencer for a synchronous 32-bit bus of the kind found next to a processor core. One request goes in at a time on a valid/ready pair. The request carries a cycle kind, a word address, byte enables, write data, a cacheable flag and a lock flag. The block opens the bus cycle with a one-clock address strobe and holds the cycle definition, address and byte enables steady. It then waits for the responding device to finish the cycle with either a single-transfer acknowledge or a burst acknowledge.

A cacheable, unlocked read of code or memory becomes a four-word line fill if the device raises the cache-enable input in the clock before the first acknowledge. The words are fetched by burst with a stepping low address, and the last-transfer output marks the word that closes the cycle. A back-off input can take the bus away at any point of a cycle. The block then floats its drivers, waits, and reopens the interrupted transfer with a new address strobe. Every completed transfer is reported one clock later on a response port with its data and an end-of-cycle flag.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: An accepted request produces an address strobe for exactly one clock. In that same clock `cyc_type` shows the request kind unchanged: bit 2 memory/IO, bit 1 data/control, bit 0 write/read, so 110 is memory read, 100 code read and 111 memory write. `bus_addr` shows the request address and `bus_be` the request byte enables.
- R2: Both acknowledges are ignored while no cycle is open, and also in the clock of the address strobe. No transfer and no response follow from them.
- R3: A cycle that is not a line fill ends on the first acknowledge of either kind from its second clock onward. `last_xfer` is high in that clock and the bus goes idle.
- R4: A line fill is started only by kind 100 or 110 with the cacheable flag set and the lock flag clear, when `line_ok` is high in the clock before the first acknowledge. A line fill takes four burst transfers, and `last_xfer` is high only in the fourth. A `line_ok` seen only in the acknowledge clock has no effect.
- R5: If the single-transfer acknowledge comes in the same clock as the burst acknowledge, that transfer is the last of the cycle, even when line-fill words remain.
- R6: `backoff` overrides both acknowledges in the same clock, and no transfer is taken. `bus_released` is high from the next clock for as long as `backoff` stays high. One clock after release, a new address strobe reopens the interrupted word at the same address.
- R7: A locked request is never turned into a line fill. `bus_locked` is high in every clock from its address strobe through its final acknowledge clock, and low after.
- R8: Line-fill word addresses step the two low address bits by +1 per transfer modulo 4, starting from the requested word (default order).
- R9: For write kinds (bit 0 set), `bus_dout_en` is high with the request data on `bus_dout` from the second clock of the cycle.
- R10: Each transfer gives one `rsp_valid` pulse one clock after its acknowledge, with the sampled `bus_din` on `rsp_data`. `rsp_last` is set on the transfer that ends the cycle.
- R11: While waiting for an acknowledge, the cycle definition and address stay stable and no further address strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock if valid |
| req_type | input | 3 | Cycle kind |
| req_addr | input | 30 | Word address |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| req_cacheable | input | 1 | Read may become a line fill |
| req_lock | input | 1 | Locked cycle |
| addr_strobe | output | 1 | First clock of a cycle |
| cyc_type | output | 3 | Cycle definition |
| bus_addr | output | 30 | Current word address |
| bus_be | output | 4 | Byte enables |
| bus_dout | output | 32 | Write data |
| bus_dout_en | output | 1 | Write data driven |
| bus_din | input | 32 | Read data |
| xfer_done | input | 1 | Single-transfer acknowledge |
| burst_ack | input | 1 | Burst acknowledge |
| line_ok | input | 1 | Device allows a line fill |
| backoff | input | 1 | Give up the bus now |
| last_xfer | output | 1 | Next acknowledge ends the cycle |
| bus_locked | output | 1 | Locked cycle in progress |
| bus_released | output | 1 | Drivers floated by back-off |
| rsp_valid | output | 1 | Transfer completed |
| rsp_data | output | 32 | Data of that transfer |
| rsp_last | output | 1 | Transfer ended the cycle |

## Verification
The bench drives acknowledges in the strobe clock and while idle. A design that sampled them too early would report a spurious transfer. It raises the cache-enable input only in the acknowledge clock, and gives locked cacheable reads with cache-enable high. A wrong fill decision in either case shows up as four transfers where one is expected, or as a `last_xfer` in the wrong clock. It sends both acknowledges together in the middle of a fill, which a wrong priority would let run past the early end. It also pulls back-off together with an acknowledge before the first word and between fill words. A design that took the transfer, reopened at the wrong word or lost the fill decision would return wrong data, a wrong address or a wrong word count.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_BACK = 2'd3
   } bcc_state_e;

   typedef enum logic [2:0] {
      CY_INTA    = 3'b000,
      CY_SPECIAL = 3'b001,
      CY_IO_RD   = 3'b010,
      CY_IO_WR   = 3'b011,
      CY_CODE_RD = 3'b100,
      CY_RSVD    = 3'b101,
      CY_MEM_RD  = 3'b110,
      CY_MEM_WR  = 3'b111
   } bcc_kind_e;

   typedef struct packed {
      bcc_kind_e kind;
      logic      cache;
      logic      lock;
   } bcc_attr_t;

   function automatic logic attr_fillable(bcc_attr_t a);
      return ((a.kind == CY_CODE_RD) || (a.kind == CY_MEM_RD)) && a.cache && !a.lock;
   endfunction

   function automatic logic kind_writes(bcc_kind_e k);
      return k[0];
   endfunction

endpackage

// File: rtl/bcc_beat.sv
module bcc_beat #(
   parameter int LINE_BEATS = 4,
   parameter int BEAT_ORDER = 0,
   localparam int BEAT_W = $clog2(LINE_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BEAT_W-1:0] start_lo,
   input  logic              step,
   output logic [BEAT_W-1:0] beat_lo,
   output logic              beat_zero,
   output logic              beat_last
);

   logic [BEAT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         start_q <= '0;
      end else if (load) begin
         cnt_q   <= '0;
         start_q <= start_lo;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   generate
      if (BEAT_ORDER == 0) begin : g_wrap
         assign beat_lo = start_q + cnt_q;
      end else begin : g_xor
         assign beat_lo = start_q ^ cnt_q;
      end
   endgenerate

   assign beat_zero = (cnt_q == '0);
   assign beat_last = (cnt_q == BEAT_W'(LINE_BEATS - 1));

   AST_BEAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !beat_last); // R4

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
   import bcc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       fill_ok,
   input  logic       line_ok,
   input  logic       backoff,
   input  logic       xfer_done,
   input  logic       burst_ack,
   input  logic       beat_zero,
   input  logic       beat_last,
   output bcc_state_e state,
   output logic       fill_q,
   output logic       xfer,
   output logic       cyc_end,
   output logic       step
);

   bcc_state_e st_q, st_d;
   logic       open_w;

   assign open_w  = (st_q == ST_ADDR) || (st_q == ST_DATA);
   assign xfer    = (st_q == ST_DATA) && !backoff && (xfer_done || burst_ack);
   assign cyc_end = xfer && (xfer_done || !fill_q || beat_last);
   assign step    = xfer && !cyc_end;
   assign state   = st_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (take) st_d = ST_ADDR;
         ST_ADDR: st_d = backoff ? ST_BACK : ST_DATA;
         ST_DATA: begin
            if (backoff)      st_d = ST_BACK;
            else if (cyc_end) st_d = ST_IDLE;
         end
         ST_BACK: if (!backoff) st_d = ST_ADDR;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fill_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (take)
            fill_q <= 1'b0;
         else if (open_w && backoff && beat_zero)
            fill_q <= 1'b0;
         else if (open_w && !xfer && beat_zero)
            fill_q <= fill_ok && line_ok;
      end
   end

   AST_BACKOFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (open_w && backoff) |=> (st_q == ST_BACK)); // R6

   AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != ST_IDLE) && !beat_zero) |-> $stable(fill_q)); // R4

endmodule

// File: rtl/bcc_rsp.sv
module bcc_rsp #(
   parameter int DATA_W  = 32,
   parameter int RSP_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer,
   input  logic              cyc_end,
   input  logic [DATA_W-1:0] din,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_last
);

   generate
      if (RSP_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_valid <= 1'b0;
               rsp_data  <= '0;
               rsp_last  <= 1'b0;
            end else begin
               rsp_valid <= xfer;
               rsp_last  <= cyc_end;
               if (xfer) rsp_data <= din;
            end
         end
      end else begin : g_comb
         assign rsp_valid = xfer;
         assign rsp_data  = din;
         assign rsp_last  = cyc_end;
      end
   endgenerate

   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> rsp_valid); // R10

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
   import bcc_pkg::*;
#(
   parameter int ADDR_W     = 30,
   parameter int DATA_W     = 32,
   parameter int LINE_BEATS = 4,
   parameter int BEAT_ORDER = 0,
   parameter int RSP_REG    = 1,
   localparam int BE_W   = DATA_W / 8,
   localparam int BEAT_W = $clog2(LINE_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_cacheable,
   input  logic              req_lock,
   output logic              addr_strobe,
   output logic [2:0]        cyc_type,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BE_W-1:0]   bus_be,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              xfer_done,
   input  logic              burst_ack,
   input  logic              line_ok,
   input  logic              backoff,
   output logic              last_xfer,
   output logic              bus_locked,
   output logic              bus_released,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_last
);

   initial begin
      AST_CFG_DATA_W: assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $error("DATA_W must be a multiple of 8"); // R1
      AST_CFG_BEATS: assert (LINE_BEATS >= 2 && (1 << BEAT_W) == LINE_BEATS)
         else $error("LINE_BEATS must be a power of two of at least 2"); // R4
      AST_CFG_ADDR_W: assert (ADDR_W > BEAT_W)
         else $error("ADDR_W too small for the line"); // R8
   end

   bcc_attr_t         attr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] wdata_q;

   bcc_state_e        state;
   logic              fill_q, xfer, cyc_end, step;
   logic              take, active;
   logic [BEAT_W-1:0] beat_lo;
   logic              beat_zero, beat_last;

   assign req_ready = (state == ST_IDLE) && !backoff;
   assign take      = req_valid && req_ready;
   assign active    = (state == ST_ADDR) || (state == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q  <= '{kind: CY_INTA, cache: 1'b0, lock: 1'b0};
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else if (take) begin
         attr_q  <= '{kind: bcc_kind_e'(req_type), cache: req_cacheable, lock: req_lock};
         addr_q  <= req_addr;
         be_q    <= req_be;
         wdata_q <= req_wdata;
      end
   end

   bcc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .fill_ok   (attr_fillable(attr_q)),
      .line_ok   (line_ok),
      .backoff   (backoff),
      .xfer_done (xfer_done),
      .burst_ack (burst_ack),
      .beat_zero (beat_zero),
      .beat_last (beat_last),
      .state     (state),
      .fill_q    (fill_q),
      .xfer      (xfer),
      .cyc_end   (cyc_end),
      .step      (step)
   );

   bcc_beat #(
      .LINE_BEATS (LINE_BEATS),
      .BEAT_ORDER (BEAT_ORDER)
   ) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take),
      .start_lo  (req_addr[BEAT_W-1:0]),
      .step      (step),
      .beat_lo   (beat_lo),
      .beat_zero (beat_zero),
      .beat_last (beat_last)
   );

   bcc_rsp #(
      .DATA_W  (DATA_W),
      .RSP_REG (RSP_REG)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer      (xfer),
      .cyc_end   (cyc_end),
      .din       (bus_din),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_last  (rsp_last)
   );

   assign addr_strobe  = (state == ST_ADDR);
   assign cyc_type     = attr_q.kind;
   assign bus_addr     = {addr_q[ADDR_W-1:BEAT_W], beat_lo};
   assign bus_be       = be_q;
   assign bus_dout     = wdata_q;
   assign bus_dout_en  = (state == ST_DATA) && kind_writes(attr_q.kind);
   assign last_xfer    = active && (!fill_q || beat_last);
   assign bus_locked   = active && attr_q.lock;
   assign bus_released = (state == ST_BACK);

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |=> !addr_strobe); // R1

   AST_NO_RSP_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (RSP_REG != 0 && addr_strobe) |=> !rsp_valid); // R2

   AST_LOCK_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_locked |-> !fill_q); // R7

   AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !addr_strobe) |-> $stable(cyc_type)); // R11

   AST_BURST_END_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && !xfer_done) |-> last_xfer); // R4

endmodule

// File: tb/bus_cycle_ctrl_tb.sv
module bus_cycle_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_type = '0;
   logic [29:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        req_cacheable = 1'b0;
   logic        req_lock = 1'b0;
   logic        addr_strobe;
   logic [2:0]  cyc_type;
   logic [29:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_dout;
   logic        bus_dout_en;
   logic [31:0] bus_din = '0;
   logic        xfer_done = 1'b0;
   logic        burst_ack = 1'b0;
   logic        line_ok = 1'b0;
   logic        backoff = 1'b0;
   logic        last_xfer;
   logic        bus_locked;
   logic        bus_released;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_last;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_cycle_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .req_cacheable(req_cacheable), .req_lock(req_lock), .addr_strobe(addr_strobe),
      .cyc_type(cyc_type), .bus_addr(bus_addr), .bus_be(bus_be), .bus_dout(bus_dout),
      .bus_dout_en(bus_dout_en), .bus_din(bus_din), .xfer_done(xfer_done),
      .burst_ack(burst_ack), .line_ok(line_ok), .backoff(backoff), .last_xfer(last_xfer),
      .bus_locked(bus_locked), .bus_released(bus_released), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_last(rsp_last)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic fillable(input logic [2:0] t, input logic c, input logic l);
      return (t == 3'b100 || t == 3'b110) && c && !l;
   endfunction

   function automatic logic [29:0] word_addr(input logic [29:0] a, input int b);
      logic [1:0] lo;
      lo = a[1:0] + 2'(b);
      return {a[29:2], lo};
   endfunction

   // ken_mode: 0 low, 1 high from strobe clock, 2 high only in first acknowledge clock
   task automatic do_cycle(input logic [2:0] t, input logic [29:0] a, input logic [3:0] be,
                           input logic c, input logic l, input int ken_mode, input int ws,
                           input bit single_burst, input int abort_at, input int boff_at,
                           input bit early);
      logic        fill_exp;
      int          nb;
      int          b;
      int          boff_left;
      logic [31:0] d;
      logic [31:0] wd;
      bit          aborting;
      bit          fin;
      fill_exp  = fillable(t, c, l) && (ken_mode == 1);
      nb        = fill_exp ? 4 : 1;
      boff_left = boff_at;
      wd        = $urandom;
      @(negedge clk);
      chk("R2 ready when idle", req_ready, 1'b1);
      req_valid = 1'b1; req_type = t; req_addr = a; req_be = be;
      req_wdata = wd; req_cacheable = c; req_lock = l;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 strobe", addr_strobe, 1'b1);
      chk("R1 type", cyc_type, t);
      chk("R1 addr", bus_addr, a);
      chk("R1 be", bus_be, be);
      chk("R7 lock from strobe", bus_locked, l);
      line_ok = (ken_mode == 1);
      xfer_done = early; burst_ack = early;
      @(negedge clk);
      xfer_done = 1'b0; burst_ack = 1'b0;
      if (early) chk("R2 ack in strobe clock ignored", rsp_valid, 1'b0);
      chk("R11 single strobe", addr_strobe, 1'b0);
      if (t[0]) begin
         chk("R9 dout enable", bus_dout_en, 1'b1);
         chk("R9 dout", bus_dout, wd);
      end
      b = 0;
      fin = 0;
      while (!fin) begin
         for (int w = 0; w < ws; w++) begin
            chk("R11 no strobe while waiting", addr_strobe, 1'b0);
            chk("R11 addr stable", bus_addr, word_addr(a, b));
            chk("R11 type stable", cyc_type, t);
            @(negedge clk);
         end
         chk("R4 last_xfer", last_xfer, (!fill_exp || b == 3));
         chk("R8 beat addr", bus_addr, word_addr(a, b));
         chk("R7 lock held", bus_locked, l);
         d = $urandom;
         bus_din = d;
         if (ken_mode == 2 && b == 0) line_ok = 1'b1;
         if (b == boff_left) begin
            backoff = 1'b1; burst_ack = 1'b1; xfer_done = 1'($urandom % 2);
            @(negedge clk);
            backoff = 1'b0; burst_ack = 1'b0; xfer_done = 1'b0;
            chk("R6 released", bus_released, 1'b1);
            chk("R6 no transfer", rsp_valid, 1'b0);
            @(negedge clk);
            chk("R6 restrobe", addr_strobe, 1'b1);
            chk("R6 restart addr", bus_addr, word_addr(a, b));
            boff_left = -1;
            @(negedge clk);
            continue;
         end
         aborting = fill_exp && (b == abort_at) && (b < 3);
         if (aborting) begin
            xfer_done = 1'b1; burst_ack = 1'b1;
         end else if (fill_exp || single_burst) begin
            burst_ack = 1'b1;
         end else begin
            xfer_done = 1'b1;
         end
         @(negedge clk);
         xfer_done = 1'b0; burst_ack = 1'b0;
         if (ken_mode == 2) line_ok = 1'b0;
         fin = aborting || (b == nb - 1);
         chk("R10 rsp valid", rsp_valid, 1'b1);
         chk("R10 rsp data", rsp_data, d);
         if (aborting) chk("R5 early end", rsp_last, 1'b1);
         else          chk("R10 rsp last", rsp_last, fin);
         if (fin) begin
            chk("R7 lock dropped", bus_locked, 1'b0);
            chk("R3 idle after end", addr_strobe, 1'b0);
            chk("R3 no released", bus_released, 1'b0);
         end
         b = b + 1;
      end
      line_ok = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0BCC));
      repeat (3) @(negedge clk);
      chk("R2 reset strobe", addr_strobe, 1'b0);
      chk("R10 reset rsp", rsp_valid, 1'b0);
      chk("R7 reset lock", bus_locked, 1'b0);
      chk("R6 reset released", bus_released, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: acknowledges while idle
      xfer_done = 1'b1; burst_ack = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0; burst_ack = 1'b0;
      chk("R2 idle ack ignored", rsp_valid, 1'b0);
      chk("R2 idle no strobe", addr_strobe, 1'b0);
      // R3 single read, both ack kinds
      do_cycle(3'b110, 30'h0000_1234, 4'hF, 1'b0, 1'b0, 0, 0, 1'b0, -1, -1, 1'b0);
      do_cycle(3'b010, 30'h0000_0041, 4'h3, 1'b0, 1'b0, 0, 2, 1'b1, -1, -1, 1'b0);
      // R2 ack in strobe clock
      do_cycle(3'b110, 30'h0000_0200, 4'hF, 1'b0, 1'b0, 0, 1, 1'b0, -1, -1, 1'b1);
      // R4 R8 line fill from word 2, with wait states
      do_cycle(3'b110, 30'h0ABC_0006, 4'h1, 1'b1, 1'b0, 1, 1, 1'b1, -1, -1, 1'b0);
      do_cycle(3'b100, 30'h0000_0013, 4'hF, 1'b1, 1'b0, 1, 0, 1'b1, -1, -1, 1'b0);
      // R4 line_ok only in the acknowledge clock
      do_cycle(3'b110, 30'h0000_0300, 4'hF, 1'b1, 1'b0, 2, 0, 1'b1, -1, -1, 1'b0);
      // R7 locked cacheable read
      do_cycle(3'b110, 30'h0000_0404, 4'hF, 1'b1, 1'b1, 1, 1, 1'b1, -1, -1, 1'b0);
      // R5 abort in mid fill
      do_cycle(3'b100, 30'h0000_0501, 4'hF, 1'b1, 1'b0, 1, 0, 1'b1, 1, -1, 1'b0);
      // R6 backoff before first word and between fill words
      do_cycle(3'b110, 30'h0000_0600, 4'hF, 1'b1, 1'b0, 1, 0, 1'b1, -1, 0, 1'b0);
      do_cycle(3'b110, 30'h0000_0702, 4'hF, 1'b1, 1'b0, 1, 1, 1'b1, -1, 2, 1'b0);
      // R9 writes
      do_cycle(3'b111, 30'h0000_0803, 4'hC, 1'b1, 1'b1, 1, 1, 1'b0, -1, 0, 1'b0);
      // random mix
      for (int i = 0; i < 60; i++) begin
         logic [2:0] rt;
         logic       rc, rl;
         int         rk, rws, rab, rbo;
         rt  = 3'($urandom);
         rc  = 1'($urandom);
         rl  = ($urandom % 4) == 0;
         rk  = $urandom % 2;
         rws = $urandom % 3;
         rab = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
         rbo = (($urandom % 4) == 0) ? int'($urandom % ((fillable(rt, rc, rl) && rk == 1) ? 4 : 1)) : -1;
         do_cycle(rt, 30'($urandom), 4'($urandom), rc, rl, rk, rws, 1'($urandom),
                  rab, rbo, 1'($urandom));
      end
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule